// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Per-Bank State Tracking

This block sits beside a DDR-style memory command bus and interprets each command on the rising clock edge. It uses chip select and the three strobes (row, column, write) to decode the command, and reads the two-bit bank select and the 12-bit address alongside it. It keeps a small state machine for each of four banks. Each command is then checked against the state of the bank it addresses, or against all banks for refresh and mode set. The block reports the command as accepted, as a no-operation, or as illegal.

Every bank machine has four named states: `BK_IDLE`, `BK_ACTIVE`, `BK_READ` and `BK_WRITE`. The transitions are:
- activate: `BK_IDLE` to `BK_ACTIVE`.
- burst start: `BK_ACTIVE` to `BK_READ` or `BK_WRITE`.
- burst restart: `BK_READ` to `BK_READ`, `BK_WRITE` to `BK_WRITE`.
- terminate: `BK_READ` or `BK_WRITE` to `BK_ACTIVE`.
- burst end: to `BK_ACTIVE`, or to `BK_IDLE` when auto-precharge was requested.
- precharge: any state to `BK_IDLE`.

A burst counter sets how long a bank stays in a burst state. Its length is programmed through mode set.

All outputs are registered. They describe the command sampled at edge N and are valid after that edge. The per-bank state is exported so that the surrounding logic can schedule timing.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While `cs_n` is high the command is a deselect: `cmd_out` reports 0 (no-operation), `illegal_out` is 0 and no bank state changes.
- R2: With `cs_n` low, the pins {`ras_n`,`cas_n`,`we_n`} decode as follows, with the code reported on `cmd_out` when the command is accepted:

  | Pins | Command | `cmd_out` |
  |------|---------|-----------|
  | 111 | no-operation | 0 |
  | 110 | terminate | 1 |
  | 101 | read | 2 |
  | 100 | write | 3 |
  | 011 | activate | 4 |
  | 010 | precharge | 5 |
  | 001 | refresh | 6 |
  | 000 | mode set | 7 |

- R3: On a bank in `BK_IDLE`, read, write and terminate are illegal. Activate moves the bank to `BK_ACTIVE` and latches the row from `addr` onto `rowcol_out`.
- R4: On a bank in `BK_ACTIVE`, read or write latches the column from `addr` onto `rowcol_out` and enters `BK_READ` or `BK_WRITE`. A second activate is illegal. Terminate is accepted as a no-operation (`cmd_out` 0, not illegal).
- R5: Refresh and mode set are accepted only while all four banks are idle. Otherwise they are illegal.
- R6: In `BK_READ`:
  - terminate returns the bank to `BK_ACTIVE`;
  - a new read restarts the burst;
  - a write is illegal.

  In `BK_WRITE` the same rules apply with read and write swapped.
- R7: Precharge is accepted in any state. With `addr[10]` low it idles only the addressed bank. With `addr[10]` high it idles all banks.
- R8: `a10_out` is set to `addr[10]` for an accepted read, write or precharge, and is 0 for any other command. A read or write with `addr[10]` high ends its uninterrupted burst in `BK_IDLE`. Without it, the burst ends in `BK_ACTIVE`.
- R9: Mode set loads the burst length from `addr[2:0]`: code 1 gives 2, code 2 gives 4, code 3 gives 8, and any other code leaves it unchanged. A burst occupies length/2 clock edges after the command edge. The length after reset is 4.
- R10: An illegal command gives `illegal_out`=1 and `cmd_out`=0, and leaves the bank states, `rowcol_out` and `bank_out` unchanged.
- R11: `bank_out` takes `ba` on every accepted activate, read, write or precharge. Reset clears all outputs and idles all banks.
- R12: `bank_state` carries 2 bits per bank, with bank b at bits [2b+1:2b]: 0 idle, 1 active, 2 read, 3 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row/column address; bit 10 qualifies; bits 2:0 carry the burst code on mode set |
| cmd_out | output | 3 | Reported command code (R2) |
| bank_out | output | 2 | Bank of the last accepted bank command |
| rowcol_out | output | 12 | Last latched row or column |
| a10_out | output | 1 | Auto-precharge / all-bank qualifier of the reported command |
| illegal_out | output | 1 | Command was illegal for the current state |
| bank_state | output | 8 | Packed per-bank state (R12) |

## Verification
The bench aims at the points where a decoder that checks only the pins goes wrong:
- **Write during a read burst.** A faulty design accepts it and jumps to the write state.
- **Read during a burst.** A design that treats this as illegal, instead of restarting the count, returns to active too early.
- **Refresh or mode set with a row open.** A faulty design accepts them.
- **Terminate on an active bank.** A faulty design flags it as illegal.

It also walks an 8-beat burst edge by edge to catch off-by-one counters, and sends an invalid burst code that must not alter the length. It resets in the middle of a burst and then checks that the default length of 4 is back.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_TERM = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_ACT  = 3'd4,
        CMD_PRE  = 3'd5,
        CMD_REF  = 3'd6,
        CMD_MRS  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_READ   = 2'd2,
        BK_WRITE  = 2'd3
    } bank_st_e;

endpackage

// File: rtl/ddr_pin_decode.sv
module ddr_pin_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b110: cmd = CMD_TERM;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b011: cmd = CMD_ACT;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = CMD_REF;
                3'b000: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/ddr_burst_cfg.sv
module ddr_burst_cfg #(
    parameter int MAX_BEATS = 8,
    parameter int DEF_CODE  = 2,
    localparam int LOG_MAX  = $clog2(MAX_BEATS),
    localparam int CW       = $clog2(MAX_BEATS / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [2:0]    code,
    output logic [CW-1:0] burst_last
);

    localparam logic [CW-1:0] DEF_LAST = CW'((1 << (DEF_CODE - 1)) - 1);

    logic [CW-1:0] last_d;

    always_comb begin
        last_d = burst_last;
        if (load && code >= 3'd1 && int'(code) <= LOG_MAX) begin
            last_d = CW'((1 << (int'(code) - 1)) - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) burst_last <= DEF_LAST;
        else        burst_last <= last_d;
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_cmd_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_rd,
    input  logic          do_wr,
    input  logic          do_term,
    input  logic          do_pre,
    input  logic          ap_req,
    input  logic [CW-1:0] burst_last,
    output bank_st_e      state_q
);

    bank_st_e      state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ap_q, ap_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ap_d    = ap_q;
        unique case (state_q)
            BK_IDLE: begin
                if (do_act) state_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (do_pre) begin
                    state_d = BK_IDLE;
                end else if (do_rd || do_wr) begin
                    state_d = do_rd ? BK_READ : BK_WRITE;
                    cnt_d   = burst_last;
                    ap_d    = ap_req;
                end
            end
            BK_READ, BK_WRITE: begin
                if (do_pre) begin
                    state_d = BK_IDLE;
                end else if (do_rd || do_wr) begin
                    state_d = do_rd ? BK_READ : BK_WRITE;
                    cnt_d   = burst_last;
                    ap_d    = ap_req;
                end else if (do_term) begin
                    state_d = BK_ACTIVE;
                end else if (cnt_q == '0) begin
                    state_d = ap_q ? BK_IDLE : BK_ACTIVE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            ap_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ap_q    <= ap_d;
        end
    end

    // R3: an idle bank can only stay idle or open a row
    a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == BK_IDLE |=> state_q inside {BK_IDLE, BK_ACTIVE});

    // R6: a read burst is entered only from an open row
    a_r6_read_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == BK_READ) |-> $past(state_q) == BK_ACTIVE);

    // R9: burst counter never exceeds the programmed length
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {BK_READ, BK_WRITE} |-> cnt_q <= burst_last);

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int MAX_BEATS = 8,
    localparam int BA_W     = $clog2(BANKS),
    localparam int CW       = $clog2(MAX_BEATS / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [2:0]           cmd_out,
    output logic [BA_W-1:0]      bank_out,
    output logic [ADDR_W-1:0]    rowcol_out,
    output logic                 a10_out,
    output logic                 illegal_out,
    output logic [2*BANKS-1:0]   bank_state
);

    cmd_e          cmd;
    cmd_e          rep;
    logic          acc, ill, all_idle;
    bank_st_e      bank_st [BANKS];
    bank_st_e      st_sel;
    logic [CW-1:0] burst_last;

    ddr_pin_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_burst_cfg #(.MAX_BEATS(MAX_BEATS), .DEF_CODE(2)) u_bl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (acc && cmd == CMD_MRS),
        .code       (addr[2:0]),
        .burst_last (burst_last)
    );

    assign st_sel = bank_st[ba];

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < BANKS; i++) begin
            if (bank_st[i] != BK_IDLE) all_idle = 1'b0;
        end
    end

    // legality of the sampled command against the addressed bank
    always_comb begin
        acc = 1'b0;
        ill = 1'b0;
        rep = CMD_NOP;
        unique case (cmd)
            CMD_NOP: ;
            CMD_TERM: begin
                if (st_sel == BK_IDLE) ill = 1'b1;
                else if (st_sel != BK_ACTIVE) acc = 1'b1;
            end
            CMD_RD:  acc = (st_sel == BK_ACTIVE) || (st_sel == BK_READ);
            CMD_WR:  acc = (st_sel == BK_ACTIVE) || (st_sel == BK_WRITE);
            CMD_ACT: acc = (st_sel == BK_IDLE);
            CMD_PRE: acc = 1'b1;
            CMD_REF, CMD_MRS: acc = all_idle;
        endcase
        if (cmd inside {CMD_RD, CMD_WR, CMD_ACT, CMD_REF, CMD_MRS}) ill = !acc;
        if (acc) rep = cmd;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));

        ddr_bank_fsm #(.CW(CW)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (acc && hit && cmd == CMD_ACT),
            .do_rd      (acc && hit && cmd == CMD_RD),
            .do_wr      (acc && hit && cmd == CMD_WR),
            .do_term    (acc && hit && cmd == CMD_TERM),
            .do_pre     (acc && cmd == CMD_PRE && (hit || addr[AP_BIT])),
            .ap_req     (addr[AP_BIT]),
            .burst_last (burst_last),
            .state_q    (bank_st[b])
        );

        assign bank_state[2*b +: 2] = bank_st[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_out     <= '0;
            bank_out    <= '0;
            rowcol_out  <= '0;
            a10_out     <= 1'b0;
            illegal_out <= 1'b0;
        end else begin
            cmd_out     <= rep;
            illegal_out <= ill;
            a10_out     <= acc && (cmd inside {CMD_RD, CMD_WR, CMD_PRE}) && addr[AP_BIT];
            if (acc && (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE})) bank_out <= ba;
            if (acc && (cmd inside {CMD_ACT, CMD_RD, CMD_WR})) rowcol_out <= addr;
        end
    end

    // R5: a reported refresh or mode set means every bank was idle
    a_r5_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_out inside {3'd6, 3'd7} |-> bank_state == '0);

    // R10: an illegal command leaves latched row/column and bank untouched
    a_r10_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_out |-> $stable(rowcol_out) && $stable(bank_out));

    // R10: illegal reports are never paired with a command code
    a_r10_illegal_nop: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_out |-> cmd_out == 3'd0);

endmodule

// File: tb/ddr_cmd_tracker_test.sv
`timescale 1ns/100ps
module ddr_cmd_tracker_test;

    typedef struct packed {
        logic        cs;
        logic [2:0]  rcw;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [2:0]  cmd;
        logic        ill;
        logic [7:0]  st;
        logic [11:0] rc;
        logic [1:0]  bk;
        logic        a10;
    } vec_t;

    localparam logic [2:0] P_NOP = 3'b111, P_TERM = 3'b110, P_RD = 3'b101, P_WR = 3'b100,
                           P_ACT = 3'b011, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{1'b0, P_REF,  2'd0, 12'h000, 3'd6, 1'b0, 8'h00, 12'h000, 2'd0, 1'b0}, // R5 R2
        '{1'b0, P_MRS,  2'd0, 12'h001, 3'd7, 1'b0, 8'h00, 12'h000, 2'd0, 1'b0}, // R9 BL2
        '{1'b0, P_RD,   2'd0, 12'h000, 3'd0, 1'b1, 8'h00, 12'h000, 2'd0, 1'b0}, // R3
        '{1'b0, P_TERM, 2'd0, 12'h000, 3'd0, 1'b1, 8'h00, 12'h000, 2'd0, 1'b0}, // R3
        '{1'b1, P_ACT,  2'd0, 12'h777, 3'd0, 1'b0, 8'h00, 12'h000, 2'd0, 1'b0}, // R1
        '{1'b0, P_ACT,  2'd0, 12'h123, 3'd4, 1'b0, 8'h01, 12'h123, 2'd0, 1'b0}, // R3
        '{1'b0, P_ACT,  2'd0, 12'h456, 3'd0, 1'b1, 8'h01, 12'h123, 2'd0, 1'b0}, // R4 R10
        '{1'b0, P_REF,  2'd0, 12'h000, 3'd0, 1'b1, 8'h01, 12'h123, 2'd0, 1'b0}, // R5
        '{1'b0, P_TERM, 2'd0, 12'h000, 3'd0, 1'b0, 8'h01, 12'h123, 2'd0, 1'b0}, // R4
        '{1'b0, P_RD,   2'd0, 12'h005, 3'd2, 1'b0, 8'h02, 12'h005, 2'd0, 1'b0}, // R4
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h01, 12'h005, 2'd0, 1'b0}, // R9 R8
        '{1'b0, P_WR,   2'd0, 12'h400, 3'd3, 1'b0, 8'h03, 12'h400, 2'd0, 1'b1}, // R8
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h00, 12'h400, 2'd0, 1'b0}, // R8
        '{1'b0, P_MRS,  2'd0, 12'h003, 3'd7, 1'b0, 8'h00, 12'h400, 2'd0, 1'b0}, // R9 BL8
        '{1'b0, P_ACT,  2'd1, 12'hABC, 3'd4, 1'b0, 8'h04, 12'hABC, 2'd1, 1'b0}, // R12
        '{1'b0, P_RD,   2'd1, 12'h020, 3'd2, 1'b0, 8'h08, 12'h020, 2'd1, 1'b0}, // R4
        '{1'b0, P_WR,   2'd1, 12'h030, 3'd0, 1'b1, 8'h08, 12'h020, 2'd1, 1'b0}, // R6
        '{1'b0, P_RD,   2'd1, 12'h010, 3'd2, 1'b0, 8'h08, 12'h010, 2'd1, 1'b0}, // R6
        '{1'b0, P_TERM, 2'd1, 12'h000, 3'd1, 1'b0, 8'h04, 12'h010, 2'd1, 1'b0}, // R6
        '{1'b0, P_RD,   2'd1, 12'h400, 3'd2, 1'b0, 8'h08, 12'h400, 2'd1, 1'b1}, // R8
        '{1'b0, P_PRE,  2'd1, 12'h000, 3'd5, 1'b0, 8'h00, 12'h400, 2'd1, 1'b0}, // R7
        '{1'b0, P_ACT,  2'd2, 12'h111, 3'd4, 1'b0, 8'h10, 12'h111, 2'd2, 1'b0}, // R11
        '{1'b0, P_ACT,  2'd3, 12'h222, 3'd4, 1'b0, 8'h50, 12'h222, 2'd3, 1'b0}, // R12
        '{1'b0, P_WR,   2'd3, 12'h033, 3'd3, 1'b0, 8'hD0, 12'h033, 2'd3, 1'b0}, // R4
        '{1'b0, P_RD,   2'd3, 12'h044, 3'd0, 1'b1, 8'hD0, 12'h033, 2'd3, 1'b0}, // R6
        '{1'b0, P_PRE,  2'd0, 12'h400, 3'd5, 1'b0, 8'h00, 12'h033, 2'd0, 1'b1}, // R7
        '{1'b1, P_MRS,  2'd2, 12'hFFF, 3'd0, 1'b0, 8'h00, 12'h033, 2'd0, 1'b0}, // R1
        '{1'b0, P_ACT,  2'd0, 12'h333, 3'd4, 1'b0, 8'h01, 12'h333, 2'd0, 1'b0}, // R3
        '{1'b0, P_RD,   2'd0, 12'h044, 3'd2, 1'b0, 8'h02, 12'h044, 2'd0, 1'b0}, // R9
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h02, 12'h044, 2'd0, 1'b0}, // R9
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h02, 12'h044, 2'd0, 1'b0}, // R9
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h02, 12'h044, 2'd0, 1'b0}, // R9
        '{1'b0, P_NOP,  2'd0, 12'h000, 3'd0, 1'b0, 8'h01, 12'h044, 2'd0, 1'b0}, // R9
        '{1'b0, P_PRE,  2'd1, 12'h000, 3'd5, 1'b0, 8'h01, 12'h044, 2'd1, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [2:0]  cmd_out;
    logic [1:0]  bank_out;
    logic [11:0] rowcol_out;
    logic        a10_out, illegal_out;
    logic [7:0]  bank_state;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cmd_out(cmd_out), .bank_out(bank_out), .rowcol_out(rowcol_out),
        .a10_out(a10_out), .illegal_out(illegal_out), .bank_state(bank_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic issue(input logic c, input logic [2:0] p, input logic [1:0] b, input logic [11:0] a);
        cs_n = c;
        {ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset cmd", 32'(cmd_out), 0);
        chk("R11 reset illegal", 32'(illegal_out), 0);
        chk("R11 reset rowcol", 32'(rowcol_out), 0);
        chk("R12 reset banks", 32'(bank_state), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].cs, TBL[i].rcw, TBL[i].ba, TBL[i].addr);
            chk($sformatf("R2 cmd v%0d", i), 32'(cmd_out), 32'(TBL[i].cmd));
            chk($sformatf("R10 illegal v%0d", i), 32'(illegal_out), 32'(TBL[i].ill));
            chk($sformatf("R12 state v%0d", i), 32'(bank_state), 32'(TBL[i].st));
            chk($sformatf("R3 rowcol v%0d", i), 32'(rowcol_out), 32'(TBL[i].rc));
            chk($sformatf("R11 bank v%0d", i), 32'(bank_out), 32'(TBL[i].bk));
            chk($sformatf("R8 a10 v%0d", i), 32'(a10_out), 32'(TBL[i].a10));
        end

        // R9: invalid burst code keeps length 8
        issue(1'b0, P_PRE, 2'd0, 12'h400);
        issue(1'b0, P_MRS, 2'd0, 12'h007);
        chk("R9 invalid code accepted", 32'(cmd_out), 7);
        issue(1'b0, P_ACT, 2'd0, 12'h010);
        issue(1'b0, P_RD, 2'd0, 12'h001);
        for (int k = 0; k < 3; k++) begin
            issue(1'b0, P_NOP, 2'd0, 12'h000);
            chk("R9 length unchanged in burst", 32'(bank_state), 32'h02);
        end
        issue(1'b0, P_NOP, 2'd0, 12'h000);
        chk("R9 length unchanged end", 32'(bank_state), 32'h01);

        // R11: reset mid-burst
        issue(1'b0, P_RD, 2'd0, 12'h002);
        chk("R6 read before reset", 32'(bank_state), 32'h02);
        rst_n = 1'b0;
        #1;
        chk("R11 async reset banks", 32'(bank_state), 0);
        chk("R11 async reset cmd", 32'(cmd_out), 0);
        chk("R11 async reset rowcol", 32'(rowcol_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: default length 4 after reset
        issue(1'b0, P_ACT, 2'd2, 12'h055);
        issue(1'b0, P_RD, 2'd2, 12'h006);
        issue(1'b0, P_NOP, 2'd0, 12'h000);
        chk("R9 default len mid", 32'(bank_state), 32'h20);
        issue(1'b0, P_NOP, 2'd0, 12'h000);
        chk("R9 default len end", 32'(bank_state), 32'h10);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule